// File: doc/BRIEF.md
# SIMD Instruction Fault Checker

This block decides which processor fault, if any, a decoded 128-bit SIMD instruction raises. It takes the relevant control-register enables, the feature-presence bits for each instruction class, the lock-prefix flag, the operating mode and the memory operand description. It also takes two late flags: a page fault from the translation logic and an unmasked numeric exception from the execution unit. The block reports one result: whether a fault occurred, its vector number and whether the fault pushes an error code. When more than one condition holds, only the highest-ranked fault is reported. The ranking, from highest to lowest, is: decode-time invalid-opcode causes, device-not-available, memory operand faults, page fault, numeric fault.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream with a single result register between them. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears on the outputs on the next edge. `in_ready` is high whenever the result register is empty or is being drained in the same cycle, so the block accepts one request per cycle when `out_ready` stays high. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken.

Top module: `simd_fault_gate`

## Requirements
- R1: Invalid opcode (vector 6, no error code) is reported when any of these holds: `cr0_em`=1; `cr4_osfxsr`=0; `lock_pfx`=1; the feature bit for the class is 0. Class 0 (add/subtract) uses `cpu_feat[0]` and class 1 (AES) uses `cpu_feat[1]`. This fault outranks every other fault.
- R2: Without an R1 cause, `cr0_ts`=1 reports device-not-available (vector 7, no error code).
- R3: With `mem_op`=1 and any of address bits 3:0 set, the block reports general protection (vector 13, error code valid) in every mode. Mode codes are 0 real, 1 virtual-8086, 2 protected, 3 compatibility and 4 64-bit.
- R4: In modes 0 and 1, general protection (vector 13, error code valid) is reported when address + size − 1 exceeds 0xFFFF. The size is in bytes.
- R5: In mode 4, an address is non-canonical when bits 63 to 47 are not all equal. A non-canonical address reports stack fault (vector 12) when `mem_ss`=1 and general protection (vector 13) otherwise, with the error code valid in both cases. This check outranks the alignment check. Modes 2 and 3 apply neither this check nor the R4 limit check.
- R6: With no higher-ranked fault and `mem_op`=1, `page_fault`=1 reports page fault (vector 14, error code valid). `page_fault` is ignored when `mem_op`=0.
- R7: A numeric exception (`numeric_exc`=1) has the lowest rank. It reports vector 19 when `cr4_osxmmexcpt`=1 and vector 6 otherwise, with no error code in either case. It is ignored for class 1.
- R8: With no fault, `res_fault`=0, `flt_vector`=0 and `flt_err_vld`=0.
- R9: An accepted request's result is on the outputs one clock later. `in_ready` equals (not `out_valid`) or `out_ready`. A stalled result holds stable, and requests presented while `in_ready`=0 are ignored.
- R10: While reset is asserted and right after it, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| cr0_em | input | 1 | Emulation enable bit |
| cr0_ts | input | 1 | Task-switched bit |
| cr4_osfxsr | input | 1 | OS SIMD state save support bit |
| cr4_osxmmexcpt | input | 1 | OS numeric exception support bit |
| op_class | input | 1 | Instruction class: 0 add/subtract, 1 AES |
| cpu_feat | input | 2 | Feature present bit per class |
| lock_pfx | input | 1 | Lock prefix present |
| cpu_mode | input | 3 | Operating mode code |
| mem_op | input | 1 | Instruction has a memory operand |
| mem_addr | input | 64 | Effective address |
| mem_size | input | 5 | Operand size in bytes |
| mem_ss | input | 1 | Reference goes through the stack segment |
| numeric_exc | input | 1 | Unmasked numeric exception after execution |
| page_fault | input | 1 | Page fault from translation |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| res_fault | output | 1 | A fault is reported |
| flt_vector | output | 8 | Fault vector number |
| flt_err_vld | output | 1 | Fault pushes a (zero) error code |

## Verification
The assertions assume that every request field is driven to a known value while `in_valid` is high. They also assume that `out_ready` and `in_valid` change only between clock edges. The stimulus meets both conditions by driving every field on the falling edge and leaving nothing undriven from time zero. The numeric and page-fault flags are presented together with the decode fields. The stimulus therefore exercises the ranking between early and late faults within a single request, without having to model timing between them. The sweeps use only mode codes 0 to 4 and sizes from 1 upward, which is the range the requirements define.

// File: rtl/simd_fault_pkg.sv
package simd_fault_pkg;
  typedef enum logic [2:0] {
    MODE_REAL   = 3'd0,
    MODE_V86    = 3'd1,
    MODE_PROT   = 3'd2,
    MODE_COMPAT = 3'd3,
    MODE_LONG   = 3'd4
  } cpu_mode_e;

  localparam logic [7:0] VEC_NONE = 8'd0;
  localparam logic [7:0] VEC_UD   = 8'd6;
  localparam logic [7:0] VEC_NM   = 8'd7;
  localparam logic [7:0] VEC_SS   = 8'd12;
  localparam logic [7:0] VEC_GP   = 8'd13;
  localparam logic [7:0] VEC_PF   = 8'd14;
  localparam logic [7:0] VEC_XM   = 8'd19;

  localparam int NUM_CLASS = 2;
  localparam int CLASS_W   = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1;
  localparam int AES_CLASS = 1;

  typedef struct packed {
    logic       fault;
    logic [7:0] vector;
    logic       err_vld;
  } fault_res_t;
endpackage

// File: rtl/simd_fault_precheck.sv
module simd_fault_precheck
  import simd_fault_pkg::*;
(
  input  logic                 em,
  input  logic                 ts,
  input  logic                 osfxsr,
  input  logic                 lock_pfx,
  input  logic [CLASS_W-1:0]   op_class,
  input  logic [NUM_CLASS-1:0] cpu_feat,
  output logic                 ud_hit,
  output logic                 nm_hit
);
  logic feat_ok;

  always_comb begin
    feat_ok = 1'b0;
    for (int c = 0; c < NUM_CLASS; c++) begin
      if (op_class == CLASS_W'(c)) feat_ok = cpu_feat[c];
    end
  end

  assign ud_hit = em | ~osfxsr | lock_pfx | ~feat_ok;
  assign nm_hit = ts;
endmodule

// File: rtl/simd_fault_memcheck.sv
module simd_fault_memcheck
  import simd_fault_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          SIZE_W     = 5,
  parameter int          ALIGN_LOG2 = 4,
  parameter int          CANON_BIT  = 47,
  parameter longint unsigned RM_LIMIT = 64'hFFFF
) (
  input  logic [2:0]        mode,
  input  logic              mem_op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              use_ss,
  output logic              gp_hit,
  output logic              ss_hit
);
  localparam int UPPER_W = ADDR_W - CANON_BIT;
  localparam logic [ADDR_W:0] LIMIT_X = (ADDR_W+1)'(RM_LIMIT);

  logic [UPPER_W-1:0] upper;
  logic [SIZE_W-1:0]  size_m1;
  logic [ADDR_W:0]    end_addr;
  logic               canonical, misalign, over_limit, small_mode, long_mode;

  assign upper      = addr[ADDR_W-1:CANON_BIT];
  assign canonical  = (&upper) | ~(|upper);
  assign misalign   = |addr[ALIGN_LOG2-1:0];
  assign size_m1    = (size == '0) ? '0 : size - 1'b1;
  assign end_addr   = {1'b0, addr} + {{(ADDR_W+1-SIZE_W){1'b0}}, size_m1};
  assign over_limit = end_addr > LIMIT_X;
  assign small_mode = (mode == MODE_REAL) || (mode == MODE_V86);
  assign long_mode  = (mode == MODE_LONG);

  always_comb begin
    gp_hit = 1'b0;
    ss_hit = 1'b0;
    if (mem_op) begin
      if (long_mode && !canonical) begin
        ss_hit = use_ss;
        gp_hit = ~use_ss;
      end else if (misalign || (small_mode && over_limit)) begin
        gp_hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (ss_hit) assert_ss_only_long_R5: assert (long_mode && use_ss && mem_op);
    if (gp_hit) assert_gp_needs_mem_R3: assert (mem_op);
  end
endmodule

// File: rtl/simd_fault_prio.sv
module simd_fault_prio
  import simd_fault_pkg::*;
(
  input  logic       ud_hit,
  input  logic       nm_hit,
  input  logic       gp_hit,
  input  logic       ss_hit,
  input  logic       mem_op,
  input  logic       page_fault,
  input  logic       numeric_exc,
  input  logic       osxmmexcpt,
  input  logic       is_aes,
  output fault_res_t res
);
  always_comb begin
    res = '{fault: 1'b0, vector: VEC_NONE, err_vld: 1'b0};
    if (ud_hit)                   res = '{1'b1, VEC_UD, 1'b0};
    else if (nm_hit)              res = '{1'b1, VEC_NM, 1'b0};
    else if (ss_hit)              res = '{1'b1, VEC_SS, 1'b1};
    else if (gp_hit)              res = '{1'b1, VEC_GP, 1'b1};
    else if (mem_op && page_fault) res = '{1'b1, VEC_PF, 1'b1};
    else if (numeric_exc && !is_aes)
      res = '{1'b1, osxmmexcpt ? VEC_XM : VEC_UD, 1'b0};
  end
endmodule

// File: rtl/simd_fault_gate.sv
module simd_fault_gate
  import simd_fault_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int SIZE_W     = 5,
  parameter int ALIGN_LOG2 = 4,
  parameter int CANON_BIT  = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              cr0_em,
  input  logic              cr0_ts,
  input  logic              cr4_osfxsr,
  input  logic              cr4_osxmmexcpt,
  input  logic              op_class,
  input  logic [1:0]        cpu_feat,
  input  logic              lock_pfx,
  input  logic [2:0]        cpu_mode,
  input  logic              mem_op,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [SIZE_W-1:0] mem_size,
  input  logic              mem_ss,
  input  logic              numeric_exc,
  input  logic              page_fault,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              res_fault,
  output logic [7:0]        flt_vector,
  output logic              flt_err_vld
);
  logic       ud_hit, nm_hit, gp_hit, ss_hit;
  fault_res_t nxt_res, res_q;
  logic       accept;

  simd_fault_precheck u_pre (
    .em       (cr0_em),
    .ts       (cr0_ts),
    .osfxsr   (cr4_osfxsr),
    .lock_pfx (lock_pfx),
    .op_class (CLASS_W'(op_class)),
    .cpu_feat (cpu_feat),
    .ud_hit   (ud_hit),
    .nm_hit   (nm_hit)
  );

  simd_fault_memcheck #(
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W),
    .ALIGN_LOG2 (ALIGN_LOG2),
    .CANON_BIT  (CANON_BIT)
  ) u_mem (
    .mode   (cpu_mode),
    .mem_op (mem_op),
    .addr   (mem_addr),
    .size   (mem_size),
    .use_ss (mem_ss),
    .gp_hit (gp_hit),
    .ss_hit (ss_hit)
  );

  simd_fault_prio u_prio (
    .ud_hit      (ud_hit),
    .nm_hit      (nm_hit),
    .gp_hit      (gp_hit),
    .ss_hit      (ss_hit),
    .mem_op      (mem_op),
    .page_fault  (page_fault),
    .numeric_exc (numeric_exc),
    .osxmmexcpt  (cr4_osxmmexcpt),
    .is_aes      (op_class == 1'(AES_CLASS)),
    .res         (nxt_res)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      res_q     <= nxt_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign res_fault   = res_q.fault;
  assign flt_vector  = res_q.vector;
  assign flt_err_vld = res_q.err_vld;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(flt_vector) && $stable(res_fault));
  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  assert_ud_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (cr0_em || lock_pfx || !cr4_osfxsr) |=> res_fault && flt_vector == VEC_UD);
  assert_errcode_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flt_err_vld |-> (flt_vector == VEC_SS || flt_vector == VEC_GP || flt_vector == VEC_PF));
  assert_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !res_fault |-> flt_vector == VEC_NONE && !flt_err_vld);
endmodule

// File: tb/simd_fault_gate_tb_top.sv
`timescale 1ns/1ps
module simd_fault_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_ready;
  logic cr0_em = 0, cr0_ts = 0, cr4_osfxsr = 1, cr4_osxmmexcpt = 0;
  logic op_class = 0;
  logic [1:0] cpu_feat = 2'b11;
  logic lock_pfx = 0;
  logic [2:0] cpu_mode = 3'd2;
  logic mem_op = 0;
  logic [63:0] mem_addr = 0;
  logic [4:0] mem_size = 5'd16;
  logic mem_ss = 0, numeric_exc = 0, page_fault = 0;
  logic out_valid, out_ready = 1;
  logic res_fault, flt_err_vld;
  logic [7:0] flt_vector;

  int n_tests = 0, n_fail = 0, cycles = 0;
  logic e_fault, e_ecv;
  logic [7:0] e_vec;
  string e_tag;

  always #2.5 clk = ~clk;

  simd_fault_gate dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cr0_em(cr0_em), .cr0_ts(cr0_ts), .cr4_osfxsr(cr4_osfxsr),
    .cr4_osxmmexcpt(cr4_osxmmexcpt), .op_class(op_class), .cpu_feat(cpu_feat),
    .lock_pfx(lock_pfx), .cpu_mode(cpu_mode), .mem_op(mem_op), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_ss(mem_ss), .numeric_exc(numeric_exc),
    .page_fault(page_fault), .out_valid(out_valid), .out_ready(out_ready),
    .res_fault(res_fault), .flt_vector(flt_vector), .flt_err_vld(flt_err_vld)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference model written from the requirement list.
  task automatic model();
    logic feat, noncanon, mis, lim;
    logic [64:0] last;
    feat = op_class ? cpu_feat[1] : cpu_feat[0];
    noncanon = mem_addr[63:47] != {17{mem_addr[47]}};
    mis = mem_addr[3:0] != 4'd0;
    last = {1'b0, mem_addr} + 65'(mem_size) - 65'd1;
    lim = last > 65'h0FFFF;
    e_fault = 1; e_ecv = 0;
    if (cr0_em || !cr4_osfxsr || lock_pfx || !feat) begin e_vec = 6; e_tag = "R1"; end
    else if (cr0_ts) begin e_vec = 7; e_tag = "R2"; end
    else if (mem_op && cpu_mode == 3'd4 && noncanon) begin
      e_vec = mem_ss ? 8'd12 : 8'd13; e_ecv = 1; e_tag = "R5";
    end
    else if (mem_op && mis) begin e_vec = 13; e_ecv = 1; e_tag = "R3"; end
    else if (mem_op && cpu_mode <= 3'd1 && lim) begin e_vec = 13; e_ecv = 1; e_tag = "R4"; end
    else if (mem_op && page_fault) begin e_vec = 14; e_ecv = 1; e_tag = "R6"; end
    else if (numeric_exc && !op_class) begin
      e_vec = cr4_osxmmexcpt ? 8'd19 : 8'd6; e_tag = "R7";
    end
    else begin e_fault = 0; e_vec = 0; e_tag = "R8"; end
  endtask

  task automatic compare();
    check({e_tag, " fault"}, res_fault, e_fault);
    check({e_tag, " vector"}, flt_vector, e_vec);
    check({e_tag, " errcode"}, flt_err_vld, e_ecv);
  endtask

  // One request; called at a falling edge with fields already set.
  task automatic send();
    model();
    in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check("R9 out_valid one cycle after accept", out_valid, 1);
    compare();
    @(negedge clk);
  endtask

  function automatic logic [63:0] addr_of(int i);
    case (i)
      0: return 64'h0;
      1: return 64'h8;
      2: return 64'hFFF0;
      3: return 64'hFFF0;
      4: return 64'h1_0000;
      5: return 64'h0000_8000_0000_0000;
      6: return 64'hFFFF_8000_0000_0000;
      default: return 64'h0000_8000_0000_0004;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R10 out_valid in reset", out_valid, 0);
    check("R10 in_ready in reset", in_ready, 1);
    rst_n = 1;
    @(negedge clk);
    check("R10 out_valid after reset", out_valid, 0);

    // Sweep of all decode, enable and late flags on an aligned protected-mode access.
    mem_op = 1; mem_addr = 64'h100; cpu_mode = 3'd2; mem_size = 5'd16;
    for (int v = 0; v < 1024; v++) begin
      {cr0_em, cr0_ts, cr4_osfxsr, cr4_osxmmexcpt, op_class,
       cpu_feat, lock_pfx, numeric_exc, page_fault} = 10'(v);
      send();
    end

    // Sweep of modes and addresses with clean enables.
    cr0_em = 0; cr0_ts = 0; cr4_osfxsr = 1; lock_pfx = 0; cpu_feat = 2'b11; op_class = 0;
    for (int m = 0; m < 5; m++)
      for (int a = 0; a < 8; a++)
        for (int f = 0; f < 16; f++) begin
          cpu_mode = 3'(m);
          mem_addr = addr_of(a);
          mem_size = (a == 3) ? 5'd17 : 5'd16;
          {mem_op, mem_ss, page_fault, numeric_exc} = 4'(f);
          cr4_osxmmexcpt = f[0];
          send();
        end

    // Back-pressure: stalled result holds and new requests are ignored (R9).
    out_ready = 0; cr0_em = 1; mem_op = 0; numeric_exc = 0; page_fault = 0;
    in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    cr0_em = 0;
    for (int k = 0; k < 3; k++) begin
      check("R9 stalled valid", out_valid, 1);
      check("R9 in_ready low while stalled", in_ready, 0);
      check("R9 stalled vector held", flt_vector, 6);
      @(negedge clk);
    end
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    check("R9 ignored request not captured", out_valid, 0);

    // Back-to-back acceptance while draining.
    cr0_ts = 1; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    check("R9 first of pair", flt_vector, 7);
    check("R9 in_ready while draining", in_ready, 1);
    cr0_ts = 0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check("R9 second of pair valid", out_valid, 1);
    check("R8 second of pair clean", flt_vector, 0);
    @(negedge clk);

    summary();
    $finish;
  end
endmodule